// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block is the front end of an SDRAM controller. It takes a device that has just been powered up and brings it into normal operation. After that it keeps the device's contents alive with periodic refresh. It drives only the command and address lines that this work needs. Read and write transfers, bank tracking and the physical pad interface belong to other blocks.

A single `start` pulse launches a fixed bring-up order:

1. precharge of every bank;
2. a burst of auto-refresh commands;
3. one mode-register write that carries a programmed value on the address bus.

Between any two commands the sequencer inserts a parameterised minimum run of idle cycles (`T_RP`, `T_RFC`, `T_MRD`, each at least 1). Once the mode-register write has settled, the block raises `ready` and `refresh_en`. From then on a two-stage timer schedules auto-refresh commands: a prescaler divides the clock, and a refresh counter counts prescaler ticks.

Command codes on `cmd_out` are: 0 idle (NOP), 1 precharge-all, 2 auto refresh, 3 mode-register write.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is held, and after reset until `start` is seen, `cmd_out` is 0 (NOP), `addr_out` is 0, and `ready` and `refresh_en` are low.
- R2: When `start` is sampled high at a clock edge while the block is idle, `cmd_out` shows precharge-all (code 1) in the very next cycle.
- R3: Exactly `INIT_REFRESHES` (default 8) auto-refresh commands (code 2) follow the precharge. The first comes `T_RP`+1 cycles after the precharge, and each later one comes `T_RFC`+1 cycles after the one before.
- R4: The mode-register write (code 3) comes `T_RFC`+1 cycles after the last bring-up refresh. In that cycle `addr_out` equals `mode_value` as sampled at the preceding edge.
- R5: `ready` and `refresh_en` rise together `T_MRD`+1 cycles after the mode-register write. They stay high until reset.
- R6: In normal operation an auto refresh is issued every (`timer_reload`+1)×(`prescale_reload`+1) cycles. The first one comes that many cycles after the first cycle in which `ready` is high.
- R7: Every command lasts exactly one cycle, and every other cycle drives NOP. `addr_out` is 0 in every cycle that is not a mode-register write.
- R8: `start` has no effect once the block has left the idle state, both during bring-up and in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up order (used only while idle) |
| prescale_reload | input | PRE_W | Prescaler reload value; a tick every value+1 cycles |
| timer_reload | input | TMR_W | Refresh counter reload; a refresh every value+1 ticks |
| mode_value | input | ADDR_W | Value placed on the address bus with the mode-register write |
| cmd_out | output | 2 | Command code: 0 NOP, 1 precharge-all, 2 auto refresh, 3 mode write |
| addr_out | output | ADDR_W | Address bus; carries the mode value only during the mode write |
| ready | output | 1 | Normal operation reached |
| refresh_en | output | 1 | Periodic refresh enabled |

## Verification
The checker watches several rules on every cycle:
- every command pulse lasts a single cycle;
- the address bus stays at zero outside the mode write, and carries the sampled mode value during it;
- exactly the configured number of refreshes precede the mode write;
- precharge and mode writes never appear once `ready` is high;
- `ready` never falls without reset.

Only the bench's scenarios can show the exact idle spacing between bring-up commands and the refresh interval for a given pair of reload values. The same holds for the fact that `start` pulses after the idle state change nothing. The bench covers these with two reload settings and checks each command against a scoreboard of expected cycles.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP       = 2'd0,
        CMD_PRECHARGE = 2'd1,
        CMD_REFRESH   = 2'd2,
        CMD_MODE_SET  = 2'd3
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_INIT_REF = 3'd1,
        PH_MODE     = 3'd2,
        PH_SETTLE   = 3'd3,
        PH_RUN      = 3'd4
    } seq_phase_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_value,
    output logic             idle
);
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (load) begin
            gap_q <= load_value;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign idle = (gap_q == '0);
endmodule

// File: rtl/sdram_refresh_prescaler.sv
module sdram_refresh_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;

    assign tick = enable && (div_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            div_q <= reload;
        end else if (div_q == '0) begin
            div_q <= reload;
        end else begin
            div_q <= div_q - 1'b1;
        end
    end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic [TMR_W-1:0] reload,
    output logic             request
);
    logic [TMR_W-1:0] left_q;

    assign request = tick && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            left_q <= reload;
        end else if (tick) begin
            left_q <= (left_q == '0) ? reload : left_q - 1'b1;
        end
    end
endmodule

// File: rtl/sdram_bringup_ctrl.sv
module sdram_bringup_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W         = 13,
    parameter int GAP_W          = 3,
    parameter int T_RP           = 2,
    parameter int T_RFC          = 4,
    parameter int T_MRD          = 2,
    parameter int INIT_REFRESHES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              gap_idle,
    input  logic              refresh_req,
    input  logic [ADDR_W-1:0] mode_value,
    output logic              gap_load,
    output logic [GAP_W-1:0]  gap_value,
    output sdram_cmd_e        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o,
    output logic              run_o
);
    localparam int CNT_W = $clog2(INIT_REFRESHES + 1);

    seq_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] refs_q, refs_d;
    logic             pend_q, pend_d;
    logic             ready_d;
    sdram_cmd_e       issue;

    always_comb begin
        phase_d   = phase_q;
        refs_d    = refs_q;
        pend_d    = pend_q | refresh_req;
        ready_d   = ready_o;
        issue     = CMD_NOP;
        gap_load  = 1'b0;
        gap_value = '0;
        case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    issue     = CMD_PRECHARGE;
                    gap_load  = 1'b1;
                    gap_value = GAP_W'(T_RP);
                    refs_d    = '0;
                    phase_d   = PH_INIT_REF;
                end
            end
            PH_INIT_REF: begin
                if (gap_idle) begin
                    issue     = CMD_REFRESH;
                    gap_load  = 1'b1;
                    gap_value = GAP_W'(T_RFC);
                    refs_d    = refs_q + 1'b1;
                    if (refs_q == CNT_W'(INIT_REFRESHES - 1)) begin
                        phase_d = PH_MODE;
                    end
                end
            end
            PH_MODE: begin
                if (gap_idle) begin
                    issue     = CMD_MODE_SET;
                    gap_load  = 1'b1;
                    gap_value = GAP_W'(T_MRD);
                    phase_d   = PH_SETTLE;
                end
            end
            PH_SETTLE: begin
                if (gap_idle) begin
                    phase_d = PH_RUN;
                    ready_d = 1'b1;
                end
            end
            PH_RUN: begin
                if (gap_idle && (pend_q || refresh_req)) begin
                    issue     = CMD_REFRESH;
                    gap_load  = 1'b1;
                    gap_value = GAP_W'(T_RFC);
                    pend_d    = 1'b0;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            refs_q  <= '0;
            pend_q  <= 1'b0;
            cmd_o   <= CMD_NOP;
            addr_o  <= '0;
            ready_o <= 1'b0;
        end else begin
            phase_q <= phase_d;
            refs_q  <= refs_d;
            pend_q  <= pend_d;
            cmd_o   <= issue;
            addr_o  <= (issue == CMD_MODE_SET) ? mode_value : '0;
            ready_o <= ready_d;
        end
    end

    assign run_o = (phase_q == PH_RUN);
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W         = 13,
    parameter int PRE_W          = 8,
    parameter int TMR_W          = 8,
    parameter int T_RP           = 2,
    parameter int T_RFC          = 4,
    parameter int T_MRD          = 2,
    parameter int INIT_REFRESHES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PRE_W-1:0]  prescale_reload,
    input  logic [TMR_W-1:0]  timer_reload,
    input  logic [ADDR_W-1:0] mode_value,
    output logic [1:0]        cmd_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              ready,
    output logic              refresh_en
);
    localparam int GAP_MAX = int'(max3(T_RP, T_RFC, T_MRD));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    logic             gap_load, gap_idle;
    logic [GAP_W-1:0] gap_value;
    logic             run, tick, req;
    sdram_cmd_e       cmd;

    sdram_gap_counter #(.GAP_W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load),
        .load_value(gap_value), .idle(gap_idle)
    );

    sdram_refresh_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .enable(run),
        .reload(prescale_reload), .tick(tick)
    );

    sdram_refresh_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .enable(run), .tick(tick),
        .reload(timer_reload), .request(req)
    );

    sdram_bringup_ctrl #(
        .ADDR_W(ADDR_W), .GAP_W(GAP_W), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .INIT_REFRESHES(INIT_REFRESHES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .gap_idle(gap_idle),
        .refresh_req(req), .mode_value(mode_value), .gap_load(gap_load),
        .gap_value(gap_value), .cmd_o(cmd), .addr_o(addr_out),
        .ready_o(ready), .run_o(run)
    );

    assign cmd_out    = cmd;
    assign refresh_en = run;
endmodule

// File: rtl/sdram_powerup_seq_checker.sv
module sdram_powerup_seq_checker
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W         = 13,
    parameter int INIT_REFRESHES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd_out,
    input logic [ADDR_W-1:0] addr_out,
    input logic [ADDR_W-1:0] mode_value,
    input logic              ready,
    input logic              refresh_en
);
    localparam int SEEN_W = $clog2(INIT_REFRESHES + 1) + 1;
    logic [SEEN_W-1:0] seen_refs;

    always_ff @(posedge clk) begin
        if (rst || cmd_out == CMD_PRECHARGE) begin
            seen_refs <= '0;
        end else if (cmd_out == CMD_REFRESH && !ready) begin
            seen_refs <= seen_refs + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cmd_out == CMD_NOP && addr_out == '0 && !ready && !refresh_en));

    p_precharge_before_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_out == CMD_PRECHARGE) |-> !ready);

    p_eight_refreshes_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_out == CMD_MODE_SET) |-> (seen_refs == SEEN_W'(INIT_REFRESHES)));

    p_refresh_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_out == CMD_REFRESH && !ready) |-> (seen_refs < SEEN_W'(INIT_REFRESHES)));

    p_mode_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_out == CMD_MODE_SET) |-> (addr_out == $past(mode_value) && !ready));

    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    p_enable_with_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ready == refresh_en);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_out != CMD_NOP) |=> (cmd_out == CMD_NOP));

    p_addr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_out != CMD_MODE_SET) |-> (addr_out == '0));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_checker #(
    .ADDR_W(ADDR_W), .INIT_REFRESHES(INIT_REFRESHES)
) u_checker (
    .clk(clk), .rst(rst), .cmd_out(cmd_out), .addr_out(addr_out),
    .mode_value(mode_value), .ready(ready), .refresh_en(refresh_en)
);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
    localparam int T_RP = 2, T_RFC = 4, T_MRD = 2, NREF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  prescale_reload = '0;
    logic [7:0]  timer_reload = '0;
    logic [12:0] mode_value = '0;
    logic [1:0]  cmd_out;
    logic [12:0] addr_out;
    logic        ready, refresh_en;

    always #5 clk = ~clk;

    sdram_powerup_seq #(
        .ADDR_W(13), .PRE_W(8), .TMR_W(8), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .INIT_REFRESHES(NREF)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .prescale_reload(prescale_reload),
        .timer_reload(timer_reload), .mode_value(mode_value), .cmd_out(cmd_out),
        .addr_out(addr_out), .ready(ready), .refresh_en(refresh_en)
    );

    typedef struct {
        int          at;
        logic [1:0]  cmd;
        logic [12:0] addr;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    int   ready_at = 32'h3fff_ffff;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(input int at, input logic [1:0] c,
                        input logic [12:0] a, input string tag);
        exp_t e;
        e.at = at; e.cmd = c; e.addr = a; e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor: samples 2 ns after each rising edge, pops the scoreboard.
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            while (expq.size() > 0 && expq[0].at < cyc) begin
                check(1'b0, expq[0].tag, "missed command", 0, int'(expq[0].cmd));
                void'(expq.pop_front());
            end
            if (expq.size() > 0 && expq[0].at == cyc) begin
                check(cmd_out == expq[0].cmd, expq[0].tag, "command code",
                      int'(cmd_out), int'(expq[0].cmd));
                check(addr_out == expq[0].addr, expq[0].tag, "address",
                      int'(addr_out), int'(expq[0].addr));
                void'(expq.pop_front());
            end else begin
                check(cmd_out == 2'd0, "R7", "unexpected command", int'(cmd_out), 0);
                check(addr_out == '0, "R7", "address outside mode write",
                      int'(addr_out), 0);
            end
            check(ready == (cyc >= ready_at), "R5", "ready",
                  int'(ready), int'(cyc >= ready_at));
            check(refresh_en == (cyc >= ready_at), "R5", "refresh_en",
                  int'(refresh_en), int'(cyc >= ready_at));
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        expq.delete();
        ready_at = 32'h3fff_ffff;
        repeat (3) @(negedge clk);
        check(cmd_out == 2'd0, "R1", "cmd in reset", int'(cmd_out), 0);
        check(addr_out == '0, "R1", "addr in reset", int'(addr_out), 0);
        check(!ready && !refresh_en, "R1", "flags in reset",
              int'({ready, refresh_en}), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);  // idle without start: monitor sees NOP only (R1)
        check(cmd_out == 2'd0 && !ready, "R1", "idle before start",
              int'(cmd_out), 0);
    endtask

    task automatic run_bringup(input logic [7:0] p, input logic [7:0] t,
                               input logic [12:0] mv, input int nper,
                               input bit poke);
        int s, pre_at, ref0, mrs_at, e, iv;
        prescale_reload = p;
        timer_reload    = t;
        mode_value      = mv;
        @(negedge clk);
        s      = cyc;
        pre_at = s + 1;
        ref0   = pre_at + T_RP + 1;
        mrs_at = ref0 + (NREF - 1) * (T_RFC + 1) + T_RFC + 1;
        e      = mrs_at + T_MRD + 1;
        iv     = (int'(t) + 1) * (int'(p) + 1);
        push(pre_at, 2'd1, '0, "R2");
        for (int i = 0; i < NREF; i++) push(ref0 + i * (T_RFC + 1), 2'd2, '0, "R3");
        push(mrs_at, 2'd3, mv, "R4");
        for (int k = 1; k <= nper; k++) push(e + k * iv, 2'd2, '0, "R6");
        ready_at = e;
        pulse_start();
        if (poke) begin
            wait_until(ref0 + 3);   // R8: start during bring-up ignored
            pulse_start();
            wait_until(e + 2);      // R8: start in normal operation ignored
            pulse_start();
        end
        wait_until(e + nper * iv + 5);
        check(expq.size() == 0, "R6", "scoreboard drained", expq.size(), 0);
    endtask

    initial begin
        do_reset();
        run_bringup(8'd3, 8'd4, 13'h0123, 3, 1'b1);
        do_reset();
        run_bringup(8'd0, 8'd9, 13'h1abc, 4, 1'b0);
        do_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule